// File: doc/BRIEF.md
# Three-Wire Synthesizer Programming Interface

This block is the control port of a frequency synthesizer. A host writes 19-bit frames over three wires: a serial clock, a serial data line and a load-enable strobe. The block samples all three wires with its own system clock through synchronizer chains. It shifts one data bit on each rising edge of the serial clock, most significant bit first. When load-enable rises, the last bit shifted in acts as a routing bit. It steers the frame either into the reference-divider and prescaler-select latches or into the swallow-count and main-count latches. The two destinations decode different field layouts from the same 19 bits.

The latched divider values drive the synthesizer's counters directly. While load-enable is high, a switch-enable output is raised, which a loop filter can use to switch in a faster settling stage. The host must keep the serial clock low whenever load-enable changes. A change made with the serial clock high is flagged as a protocol error and the frame is discarded. A reference ratio below 3 is refused, and the previous reference setting is kept.

Top module: `synth_prog_port`

## Requirements
- R1: After reset the outputs are div_ref=3, pscl_sel=1 (1 selects the 64/65 prescaler, 0 selects 128/129), cnt_swallow=0, cnt_main=3, sw_en=0 and proto_err=0.
- R2: Each rising edge of ser_clk shifts the value on ser_dat into a 19-bit register, most significant bit first. Bit 0 of that register is always the last bit shifted in and serves as the routing bit.
- R3: On a clean load with routing bit 1 and bits 14..1 at 3 or more, div_ref takes bits 14..1 and pscl_sel takes bit 15. cnt_swallow and cnt_main keep their values.
- R4: On a clean load with routing bit 0, cnt_swallow takes bits 7..1 and cnt_main takes bits 18..8. div_ref and pscl_sel keep their values.
- R5: The divider outputs change only after a rising edge of ser_le. Shifting bits and lowering ser_le leave them unchanged.
- R6: A frame with routing bit 1 whose bits 14..1 are below 3 is discarded, and both div_ref and pscl_sel keep their previous values.
- R7: If ser_le rises or falls while ser_clk is high, proto_err is set and no latch is written.
- R8: A later clean rising edge of ser_le, taken with ser_clk low, clears proto_err and transfers its frame.
- R9: sw_en is high while ser_le is high and low while ser_le is low, delayed only by the input synchronizer.
- R10: When more than 19 bits are shifted before a load, only the last 19 bits decide what is latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial shift clock; shifting happens on its rising edge |
| ser_dat | input | 1 | Serial data, most significant bit first |
| ser_le | input | 1 | Load-enable; its rising edge transfers the frame |
| div_ref | output | 14 | Latched reference divide ratio |
| pscl_sel | output | 1 | Prescaler select, 1 = 64/65, 0 = 128/129 |
| cnt_swallow | output | 7 | Latched swallow count |
| cnt_main | output | 11 | Latched main count |
| sw_en | output | 1 | Filter switch enable, follows load-enable |
| proto_err | output | 1 | Set when load-enable changes while the serial clock is high |

## Verification
The bench targets the routing bit and the bit positions in both layouts. A swapped or shifted field would put the wrong value into the wrong latch, or would touch the latch set that was not addressed. Reference ratios of 0 and 2 are loaded to show that the old reference and prescaler setting survive; a design without the floor would load a divider that cannot count. Load-enable is also toggled with the serial clock held high: a design that ignored the rule would latch the corrupted frame and leave proto_err low. Over-long frames and the extreme counts (16383, 127, 2047, 3) expose truncation and off-by-one errors in the shift register.

// File: rtl/synth_prog_pkg.sv
package synth_prog_pkg;

    // field widths of the latched values
    localparam int R_W = 14;
    localparam int A_W = 7;
    localparam int B_W = 11;

    // frame layout, derived from the widths
    localparam int CTRL_BIT = 0;
    localparam int R_LSB    = CTRL_BIT + 1;
    localparam int PSEL_BIT = R_LSB + R_W;
    localparam int A_LSB    = CTRL_BIT + 1;
    localparam int B_LSB    = A_LSB + A_W;
    localparam int FRAME_W  = B_LSB + B_W;

    // limits and reset values
    localparam int R_MIN    = 3;
    localparam int R_RST    = 3;
    localparam int A_RST    = 0;
    localparam int B_RST    = 3;
    localparam bit PSEL_RST = 1'b1;

    // serial pin indices in the synchronized pin vector
    localparam int PIN_LE  = 0;
    localparam int PIN_DAT = 1;
    localparam int PIN_CLK = 2;
    localparam int N_PINS  = 3;

    typedef struct packed {
        logic [R_W-1:0] ref_div;
        logic           psel;
        logic [A_W-1:0] swal;
        logic [B_W-1:0] main;
    } div_set_t;

endpackage

// File: rtl/synth_pin_sync.sv
module synth_pin_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_i,
    output logic [WIDTH-1:0] level_o
);

    localparam int LAST = STAGES - 1;

    for (genvar g = 0; g < WIDTH; g++) begin : g_pin
        logic [STAGES-1:0] chain_d;
        logic [STAGES-1:0] chain_q;

        always_comb begin
            chain_d = {chain_q[STAGES-1:0], pin_i[g]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain_q <= '0;
            end else begin
                chain_q <= chain_d;
            end
        end

        assign level_o[g] = chain_q[LAST];
    end

endmodule

// File: rtl/synth_shift_reg.sv
module synth_shift_reg #(
    parameter int FRAME_W = synth_prog_pkg::FRAME_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               shift_i,
    input  logic               bit_i,
    output logic [FRAME_W-1:0] word_o
);

    logic [FRAME_W-1:0] word_d;
    logic [FRAME_W-1:0] word_q;

    always_comb begin
        word_d = word_q;
        if (shift_i) begin
            word_d = {word_q[FRAME_W-2:0], bit_i};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
        end else begin
            word_q <= word_d;
        end
    end

    assign word_o = word_q;

endmodule

// File: rtl/synth_latch_bank.sv
module synth_latch_bank
    import synth_prog_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic [FRAME_W-1:0] word_i,
    output div_set_t           set_o
);

    localparam logic [R_W-1:0] R_FLOOR = R_W'(R_MIN);

    div_set_t       set_d;
    div_set_t       set_q;
    logic [R_W-1:0] ref_field;
    logic           ref_ok;

    always_comb begin
        ref_field = word_i[R_LSB +: R_W];
        ref_ok    = (ref_field >= R_FLOOR);
        set_d     = set_q;
        if (load_i) begin
            if (word_i[CTRL_BIT]) begin
                if (ref_ok) begin
                    set_d.ref_div = ref_field;
                    set_d.psel    = word_i[PSEL_BIT];
                end
            end else begin
                set_d.swal = word_i[A_LSB +: A_W];
                set_d.main = word_i[B_LSB +: B_W];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            set_q.ref_div <= R_W'(R_RST);
            set_q.psel    <= PSEL_RST;
            set_q.swal    <= A_W'(A_RST);
            set_q.main    <= B_W'(B_RST);
        end else begin
            set_q <= set_d;
        end
    end

    assign set_o = set_q;

endmodule

// File: rtl/synth_prog_port.sv
module synth_prog_port
    import synth_prog_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ser_clk,
    input  logic           ser_dat,
    input  logic           ser_le,
    output logic [R_W-1:0] div_ref,
    output logic           pscl_sel,
    output logic [A_W-1:0] cnt_swallow,
    output logic [B_W-1:0] cnt_main,
    output logic           sw_en,
    output logic           proto_err
);

    typedef struct packed {
        logic le_prev;
        logic sclk_prev;
        logic err;
    } ctl_t;

    logic [N_PINS-1:0]  pins_raw;
    logic [N_PINS-1:0]  pins_lvl;
    logic [FRAME_W-1:0] frame_w;
    div_set_t           div_set_w;
    ctl_t               ctl_d;
    ctl_t               ctl_q;

    logic le_lvl_w;
    logic sclk_lvl_w;
    logic le_rise_w;
    logic le_fall_w;
    logic sclk_rise_w;
    logic viol_w;
    logic load_w;

    always_comb begin
        pins_raw          = '0;
        pins_raw[PIN_LE]  = ser_le;
        pins_raw[PIN_DAT] = ser_dat;
        pins_raw[PIN_CLK] = ser_clk;
    end

    synth_pin_sync #(
        .WIDTH  (N_PINS),
        .STAGES (SYNC_STAGES)
    ) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_i   (pins_raw),
        .level_o (pins_lvl)
    );

    always_comb begin
        le_lvl_w    = pins_lvl[PIN_LE];
        sclk_lvl_w  = pins_lvl[PIN_CLK];
        le_rise_w   = le_lvl_w & ~ctl_q.le_prev;
        le_fall_w   = ~le_lvl_w & ctl_q.le_prev;
        sclk_rise_w = sclk_lvl_w & ~ctl_q.sclk_prev;
        viol_w      = (le_rise_w | le_fall_w) & sclk_lvl_w;
        load_w      = le_rise_w & ~sclk_lvl_w;

        ctl_d           = ctl_q;
        ctl_d.le_prev   = le_lvl_w;
        ctl_d.sclk_prev = sclk_lvl_w;
        if (viol_w) begin
            ctl_d.err = 1'b1;
        end else if (load_w) begin
            ctl_d.err = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    synth_shift_reg #(
        .FRAME_W (FRAME_W)
    ) shift_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift_i (sclk_rise_w),
        .bit_i   (pins_lvl[PIN_DAT]),
        .word_o  (frame_w)
    );

    synth_latch_bank latch_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load_w),
        .word_i (frame_w),
        .set_o  (div_set_w)
    );

    assign div_ref     = div_set_w.ref_div;
    assign pscl_sel    = div_set_w.psel;
    assign cnt_swallow = div_set_w.swal;
    assign cnt_main    = div_set_w.main;
    assign sw_en       = le_lvl_w;
    assign proto_err   = ctl_q.err;

endmodule

// File: rtl/synth_prog_chk.sv
module synth_prog_chk
    import synth_prog_pkg::*;
(
    input logic           clk,
    input logic           rst_n,
    input logic           le_rise,
    input logic           le_fall,
    input logic           sclk_lvl,
    input logic           proto_err,
    input logic [R_W-1:0] div_ref,
    input logic           pscl_sel,
    input logic [A_W-1:0] cnt_swallow,
    input logic [B_W-1:0] cnt_main
);

    // R5: latches move only after a load-enable rising edge
    assert_latch_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !le_rise |=> $stable({div_ref, pscl_sel, cnt_swallow, cnt_main}));

    // R6: the reference ratio never drops below the floor
    assert_ref_floor_R6: assert property (@(posedge clk) disable iff (!rst_n)
        div_ref >= R_W'(R_MIN));

    // R7: load-enable edge with serial clock high flags an error and latches nothing
    assert_err_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((le_rise || le_fall) && sclk_lvl) |=>
            (proto_err && $stable({div_ref, pscl_sel, cnt_swallow, cnt_main})));

    // R8: a clean load clears the error flag
    assert_err_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (le_rise && !sclk_lvl) |=> !proto_err);

endmodule

bind synth_prog_port synth_prog_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .le_rise     (le_rise_w),
    .le_fall     (le_fall_w),
    .sclk_lvl    (sclk_lvl_w),
    .proto_err   (proto_err),
    .div_ref     (div_ref),
    .pscl_sel    (pscl_sel),
    .cnt_swallow (cnt_swallow),
    .cnt_main    (cnt_main)
);

// File: tb/synth_prog_port_tb.sv
module synth_prog_port_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser_clk = 1'b0;
    logic        ser_dat = 1'b0;
    logic        ser_le = 1'b0;
    logic [13:0] div_ref;
    logic        pscl_sel;
    logic [6:0]  cnt_swallow;
    logic [10:0] cnt_main;
    logic        sw_en;
    logic        proto_err;

    int n_checks = 0;
    int n_fail   = 0;

    // expected latch contents
    int exp_ref  = 3;
    int exp_psel = 1;
    int exp_a    = 0;
    int exp_b    = 3;

    always #(CLK_PERIOD/2) clk = ~clk;

    synth_prog_port dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .ser_clk     (ser_clk),
        .ser_dat     (ser_dat),
        .ser_le      (ser_le),
        .div_ref     (div_ref),
        .pscl_sel    (pscl_sel),
        .cnt_swallow (cnt_swallow),
        .cnt_main    (cnt_main),
        .sw_en       (sw_en),
        .proto_err   (proto_err)
    );

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_all(input string req);
        chk({req, " div_ref"},     int'(div_ref),     exp_ref);
        chk({req, " pscl_sel"},    int'(pscl_sel),    exp_psel);
        chk({req, " cnt_swallow"}, int'(cnt_swallow), exp_a);
        chk({req, " cnt_main"},    int'(cnt_main),    exp_b);
    endtask

    function automatic logic [18:0] ref_frame(input int r, input int p);
        logic [13:0] rr = 14'(r);
        return {3'b000, 1'(p), rr, 1'b1};
    endfunction

    function automatic logic [18:0] n_frame(input int a, input int b);
        logic [6:0]  aa = 7'(a);
        logic [10:0] bb = 11'(b);
        return {bb, aa, 1'b0};
    endfunction

    // R2: MSB first, one bit per rising serial clock edge
    task automatic send_bits(input logic [31:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            ser_dat = v[i];
            wait_clk(HALF);
            ser_clk = 1'b1;
            wait_clk(HALF);
            ser_clk = 1'b0;
        end
        wait_clk(HALF);
    endtask

    // clean load; also checks the switch enable (R9)
    task automatic clean_load();
        ser_le = 1'b1;
        wait_clk(2 * HALF);
        chk("R9 sw_en while load high", int'(sw_en), 1);
        ser_le = 1'b0;
        wait_clk(2 * HALF);
        chk("R9 sw_en after load low", int'(sw_en), 0);
    endtask

    task automatic t_reset();
        chk_all("R1 reset");
        chk("R1 sw_en", int'(sw_en), 0);
        chk("R1 proto_err", int'(proto_err), 0);
    endtask

    task automatic t_ref_load();
        send_bits(32'(ref_frame(1234, 0)), 19);
        chk_all("R5 before load");
        clean_load();
        exp_ref  = 1234;
        exp_psel = 0;
        chk_all("R3 reference load");
    endtask

    task automatic t_n_load();
        send_bits(32'(n_frame(100, 2000)), 19);
        clean_load();
        exp_a = 100;
        exp_b = 2000;
        chk_all("R4 counter load");
    endtask

    task automatic t_ref_reject();
        send_bits(32'(ref_frame(2, 1)), 19);
        clean_load();
        chk_all("R6 ratio 2 rejected");
        send_bits(32'(ref_frame(0, 1)), 19);
        clean_load();
        chk_all("R6 ratio 0 rejected");
    endtask

    task automatic t_proto_err();
        send_bits(32'(ref_frame(500, 1)), 19);
        // toggle load-enable with the serial clock high
        ser_clk = 1'b1;
        wait_clk(HALF);
        ser_le = 1'b1;
        wait_clk(2 * HALF);
        ser_le = 1'b0;
        wait_clk(2 * HALF);
        ser_clk = 1'b0;
        wait_clk(2 * HALF);
        chk("R7 proto_err set", int'(proto_err), 1);
        chk_all("R7 no transfer");
        send_bits(32'(ref_frame(500, 1)), 19);
        chk("R7 proto_err held", int'(proto_err), 1);
        clean_load();
        exp_ref  = 500;
        exp_psel = 1;
        chk("R8 proto_err cleared", int'(proto_err), 0);
        chk_all("R8 clean transfer");
    endtask

    task automatic t_bounds();
        send_bits(32'(ref_frame(16383, 0)), 19);
        clean_load();
        exp_ref  = 16383;
        exp_psel = 0;
        chk_all("R3 max ratio");
        send_bits(32'(ref_frame(3, 1)), 19);
        clean_load();
        exp_ref  = 3;
        exp_psel = 1;
        chk_all("R3 min ratio");
        send_bits(32'(n_frame(127, 3)), 19);
        clean_load();
        exp_a = 127;
        exp_b = 3;
        chk_all("R4 max swallow");
        send_bits(32'(n_frame(0, 2047)), 19);
        clean_load();
        exp_a = 0;
        exp_b = 2047;
        chk_all("R4 max main");
    endtask

    task automatic t_long_frame();
        send_bits(32'h2D, 6);
        send_bits(32'(n_frame(85, 1365)), 19);
        clean_load();
        exp_a = 85;
        exp_b = 1365;
        chk_all("R10 long frame");
        send_bits(32'h3F, 6);
        send_bits(32'(ref_frame(9001, 0)), 19);
        clean_load();
        exp_ref  = 9001;
        exp_psel = 0;
        chk_all("R10 long reference frame");
    endtask

    initial begin
        wait_clk(3);
        rst_n = 1'b1;
        wait_clk(2);
        t_reset();
        t_ref_load();
        t_n_load();
        t_ref_reject();
        t_proto_err();
        t_bounds();
        t_long_frame();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule